// File: doc/BRIEF.md
# Accumulator Register-Operation Unit

This unit holds the 16-bit accumulator and its one-bit extension flag, and carries out the register-class instructions of a small accumulator machine. When the decoder flags opcode 7, the address-mode bit is 0 and the timing step is T3, the low twelve bits of the instruction word act as a one-hot operation field. Each bit selects one action: clear, complement, rotate through the extension, increment, a conditional skip, or halt. The unit also accepts load and add requests from the memory-operand path, so it is the only writer of the accumulator.

Each cycle, a small mode selector puts the unit into one of four named modes. The modes are MODE_IDLE, MODE_REGOP, MODE_MEMADD and MODE_MEMLOAD. MODE_REGOP is entered whenever the register-operation qualifiers are all true, and it overrides memory requests. MODE_MEMADD is entered otherwise when an add request is present. MODE_MEMLOAD is entered when only a load request is present. MODE_IDLE covers all remaining cycles. The mode is re-evaluated every cycle, so any mode may follow any other.

In MODE_REGOP the unit raises three strobes in the same cycle:
- a step-counter clear;
- a program-counter skip, when a tested condition holds;
- a halt strobe, which clears the machine's run flag.

The accumulator and extension registers update at the following clock edge.

Top module: `acc_regop_unit`

## Requirements
- R1: A register operation is carried out only when `dec_op7`=1, `addr_ind`=0 and `step_t3`=1. Outside such cycles, `op_field` changes neither the accumulator nor the extension, and `pc_skip`, `halt_clr` and `sc_clr` stay 0.
- R2: `sc_clr` is 1 in every cycle that qualifies as a register operation, whatever `op_field` holds.
- R3: The following `op_field` bits act on the values held before the instruction:
  - bit 11 (0x800) sets the accumulator to 0;
  - bit 10 (0x400) sets the extension to 0;
  - bit 9 (0x200) inverts every bit of the accumulator;
  - bit 8 (0x100) inverts the extension.
- R4: Bit 7 (0x080) rotates right through the extension. Accumulator bit 15 takes the old extension, and the extension takes old accumulator bit 0.
- R5: Bit 6 (0x040) rotates left through the extension. Accumulator bit 0 takes the old extension, and the extension takes old accumulator bit 15.
- R6: Bit 5 (0x020) adds 1 to the accumulator modulo 2^16 and leaves the extension unchanged.
- R7: `pc_skip` is 1 during the operation cycle when any of these holds:
  - bit 4 (0x010) is set and accumulator bit 15 is 0;
  - bit 3 (0x008) is set and accumulator bit 15 is 1;
  - bit 2 (0x004) is set and the accumulator is 0;
  - bit 1 (0x002) is set and the extension is 0.
- R8: Bit 0 (0x001) drives `halt_clr` to 1 during the operation cycle.
- R9: When several bits are set, every selected action reads the pre-instruction values and `pc_skip` is a single pulse if any condition holds.
  - The accumulator takes the result of the highest-numbered accumulator-writing bit among 11, 9, 7, 6 and 5.
  - The extension takes the result of the highest-numbered extension-writing bit among 10, 8, 7 and 6.
- R10: A load request (`mem_ld`=1) outside a register operation copies `mem_data` into the accumulator at the next edge and leaves the extension unchanged.
- R11: An add request (`mem_add`=1) outside a register operation sets the accumulator to the low 16 bits of accumulator plus `mem_data`, and sets the extension to the carry out.
- R12: A qualifying register operation ignores `mem_ld` and `mem_add` in the same cycle. When both memory requests arrive together, the add is performed.
- R13: After reset, the accumulator and extension are 0 and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_t3 | input | 1 | Timing step T3 is active |
| dec_op7 | input | 1 | Decoded opcode equals 7 |
| addr_ind | input | 1 | Address-mode bit of the instruction |
| op_field | input | 12 | Low twelve instruction bits, one-hot operation select |
| mem_ld | input | 1 | Load accumulator from `mem_data` |
| mem_add | input | 1 | Add `mem_data` into the accumulator with carry to extension |
| mem_data | input | 16 | Operand from the memory-operand path |
| acc_q | output | 16 | Accumulator value |
| ext_q | output | 1 | Extension flag value |
| pc_skip | output | 1 | Skip the next instruction |
| halt_clr | output | 1 | Clear the run flag |
| sc_clr | output | 1 | Clear the timing step counter |

## Verification
The assertions check the following on every cycle:
- strobes appear only in a qualifying T3 cycle, and a skip or halt never appears without the step clear;
- the registers hold when no request is present;
- the single-bit increment and right-rotate produce their results one edge later.

Other behaviour appears only in the bench scenarios, which compare against a reference model:
- which result wins when several operation bits are set;
- carry into the extension on a memory add;
- priority of a register operation over memory requests;
- the wrap of 0xFFFF on increment;
- each skip condition at its sign and zero boundaries.

// File: rtl/acc_regop_pkg.sv
`timescale 1ns/1ps
package acc_regop_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE    = 2'd0,
        MODE_REGOP   = 2'd1,
        MODE_MEMADD  = 2'd2,
        MODE_MEMLOAD = 2'd3
    } acc_mode_e;

    localparam int OP_W     = 12;
    localparam int B_CLR_AC = 11;
    localparam int B_CLR_E  = 10;
    localparam int B_INV_AC = 9;
    localparam int B_INV_E  = 8;
    localparam int B_ROT_R  = 7;
    localparam int B_ROT_L  = 6;
    localparam int B_INC    = 5;
    localparam int B_SK_POS = 4;
    localparam int B_SK_NEG = 3;
    localparam int B_SK_ZAC = 2;
    localparam int B_SK_ZE  = 1;
    localparam int B_HALT   = 0;
    localparam int N_SKIP   = 4;

endpackage

// File: rtl/acc_regop_mode_sel.sv
`timescale 1ns/1ps
module acc_regop_mode_sel
    import acc_regop_pkg::*;
(
    input  logic      step_t3,
    input  logic      dec_op7,
    input  logic      addr_ind,
    input  logic      mem_ld,
    input  logic      mem_add,
    output acc_mode_e mode
);

    logic regop_ok;

    always_comb begin
        regop_ok = step_t3 & dec_op7 & ~addr_ind;
        if (regop_ok)
            mode = MODE_REGOP;
        else if (mem_add)
            mode = MODE_MEMADD;
        else if (mem_ld)
            mode = MODE_MEMLOAD;
        else
            mode = MODE_IDLE;
    end

endmodule

// File: rtl/acc_regop_exec.sv
`timescale 1ns/1ps
module acc_regop_exec
    import acc_regop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  acc_mode_e         mode,
    input  logic [DATA_W-1:0] acc_cur,
    input  logic              ext_cur,
    input  logic [OP_W-1:0]   ops,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_nxt,
    output logic              ext_nxt,
    output logic              skip,
    output logic              halt
);

    localparam int MSB = DATA_W - 1;

    logic [N_SKIP-1:0] cond_hold;
    logic [N_SKIP-1:0] cond_sel;
    logic [DATA_W:0]   sum_w;

    assign cond_hold[3] = ~acc_cur[MSB];
    assign cond_hold[2] = acc_cur[MSB];
    assign cond_hold[1] = (acc_cur == '0);
    assign cond_hold[0] = ~ext_cur;

    genvar g;
    generate
        for (g = 0; g < N_SKIP; g++) begin : g_skip
            assign cond_sel[g] = ops[B_SK_ZE + g] & cond_hold[g];
        end
    endgenerate

    assign sum_w = {1'b0, acc_cur} + {1'b0, operand};

    always_comb begin
        acc_nxt = acc_cur;
        ext_nxt = ext_cur;
        skip    = 1'b0;
        halt    = 1'b0;
        unique case (mode)
            MODE_REGOP: begin
                if (ops[B_INC])
                    acc_nxt = acc_cur + 1'b1;
                if (ops[B_ROT_L]) begin
                    acc_nxt = {acc_cur[MSB-1:0], ext_cur};
                    ext_nxt = acc_cur[MSB];
                end
                if (ops[B_ROT_R]) begin
                    acc_nxt = {ext_cur, acc_cur[MSB:1]};
                    ext_nxt = acc_cur[0];
                end
                if (ops[B_INV_E])
                    ext_nxt = ~ext_cur;
                if (ops[B_INV_AC])
                    acc_nxt = ~acc_cur;
                if (ops[B_CLR_E])
                    ext_nxt = 1'b0;
                if (ops[B_CLR_AC])
                    acc_nxt = '0;
                skip = |cond_sel;
                halt = ops[B_HALT];
            end
            MODE_MEMADD: begin
                acc_nxt = sum_w[MSB:0];
                ext_nxt = sum_w[DATA_W];
            end
            MODE_MEMLOAD: begin
                acc_nxt = operand;
            end
            MODE_IDLE: begin
                acc_nxt = acc_cur;
            end
        endcase
    end

endmodule

// File: rtl/acc_regop_unit.sv
`timescale 1ns/1ps
module acc_regop_unit
    import acc_regop_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_t3,
    input  logic              dec_op7,
    input  logic              addr_ind,
    input  logic [11:0]       op_field,
    input  logic              mem_ld,
    input  logic              mem_add,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] acc_q,
    output logic              ext_q,
    output logic              pc_skip,
    output logic              halt_clr,
    output logic              sc_clr
);

    acc_mode_e         mode;
    logic [DATA_W-1:0] acc_nxt;
    logic              ext_nxt;
    logic              skip_w;
    logic              halt_w;

    acc_regop_mode_sel u_mode (
        .step_t3 (step_t3),
        .dec_op7 (dec_op7),
        .addr_ind(addr_ind),
        .mem_ld  (mem_ld),
        .mem_add (mem_add),
        .mode    (mode)
    );

    acc_regop_exec #(.DATA_W(DATA_W)) u_exec (
        .mode   (mode),
        .acc_cur(acc_q),
        .ext_cur(ext_q),
        .ops    (op_field),
        .operand(mem_data),
        .acc_nxt(acc_nxt),
        .ext_nxt(ext_nxt),
        .skip   (skip_w),
        .halt   (halt_w)
    );

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            ext_q <= 1'b0;
        end else begin
            acc_q <= acc_nxt;
            ext_q <= ext_nxt;
        end
    end

    // Output strobes
    always_comb begin
        sc_clr   = 1'b0;
        pc_skip  = 1'b0;
        halt_clr = 1'b0;
        unique case (mode)
            MODE_REGOP: begin
                sc_clr   = 1'b1;
                pc_skip  = skip_w;
                halt_clr = halt_w;
            end
            MODE_MEMADD, MODE_MEMLOAD, MODE_IDLE: begin
                sc_clr = 1'b0;
            end
        endcase
    end

    AST_STROBE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_skip || halt_clr || sc_clr) |-> (step_t3 && dec_op7 && !addr_ind)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(step_t3 && dec_op7 && !addr_ind) && !mem_ld && !mem_add)
        |=> ($stable(acc_q) && $stable(ext_q))); // R1

    AST_STROBE_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_skip || halt_clr) |-> sc_clr); // R2

    AST_ROT_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clr && op_field == 12'h080)
        |=> (acc_q == {$past(ext_q), $past(acc_q[DATA_W-1:1])} && ext_q == $past(acc_q[0]))); // R4

    AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_clr && op_field == 12'h020)
        |=> (acc_q == DATA_W'($past(acc_q) + 1'b1) && $stable(ext_q))); // R6

    AST_HALT_FROM_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        halt_clr |-> op_field[0]); // R8

endmodule

// File: tb/acc_regop_unit_tb.sv
`timescale 1ns/1ps
module acc_regop_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_t3 = 1'b0;
    logic        dec_op7 = 1'b0;
    logic        addr_ind = 1'b0;
    logic [11:0] op_field = '0;
    logic        mem_ld = 1'b0;
    logic        mem_add = 1'b0;
    logic [15:0] mem_data = '0;
    logic [15:0] acc_q;
    logic        ext_q;
    logic        pc_skip;
    logic        halt_clr;
    logic        sc_clr;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_acc = '0;
    logic        m_ext = 1'b0;

    always #2.5 clk = ~clk;

    acc_regop_unit u_dut (
        .clk(clk), .rst_n(rst_n), .step_t3(step_t3), .dec_op7(dec_op7),
        .addr_ind(addr_ind), .op_field(op_field), .mem_ld(mem_ld),
        .mem_add(mem_add), .mem_data(mem_data), .acc_q(acc_q), .ext_q(ext_q),
        .pc_skip(pc_skip), .halt_clr(halt_clr), .sc_clr(sc_clr)
    );

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model from the requirements
    task automatic model(input logic act, input logic [11:0] op, input logic ld,
                         input logic ad, input logic [15:0] d,
                         output logic [15:0] na, output logic ne,
                         output logic sk, output logic hl);
        logic [16:0] s;
        na = m_acc; ne = m_ext; sk = 1'b0; hl = 1'b0;
        if (act) begin
            if (op[5]) na = m_acc + 16'd1;
            if (op[6]) begin na = {m_acc[14:0], m_ext}; ne = m_acc[15]; end
            if (op[7]) begin na = {m_ext, m_acc[15:1]}; ne = m_acc[0]; end
            if (op[8]) ne = ~m_ext;
            if (op[9]) na = ~m_acc;
            if (op[10]) ne = 1'b0;
            if (op[11]) na = 16'h0000;
            sk = (op[4] && !m_acc[15]) || (op[3] && m_acc[15]) ||
                 (op[2] && m_acc == 16'h0) || (op[1] && !m_ext);
            hl = op[0];
        end else if (ad) begin
            s = {1'b0, m_acc} + {1'b0, d};
            na = s[15:0]; ne = s[16];
        end else if (ld) begin
            na = d;
        end
    endtask

    task automatic apply(input string tag, input logic t3, input logic d7,
                         input logic ib, input logic [11:0] op, input logic ld,
                         input logic ad, input logic [15:0] d);
        logic act, sk, hl, ne;
        logic [15:0] na;
        step_t3 = t3; dec_op7 = d7; addr_ind = ib; op_field = op;
        mem_ld = ld; mem_add = ad; mem_data = d;
        act = t3 && d7 && !ib;
        model(act, op, ld, ad, d, na, ne, sk, hl);
        #1;
        check(tag, "sc_clr",   {15'd0, sc_clr},   {15'd0, act});
        check(tag, "pc_skip",  {15'd0, pc_skip},  {15'd0, sk});
        check(tag, "halt_clr", {15'd0, halt_clr}, {15'd0, hl});
        @(posedge clk);
        #1;
        m_acc = na; m_ext = ne;
        check(tag, "acc", acc_q, m_acc);
        check(tag, "ext", {15'd0, ext_q}, {15'd0, m_ext});
    endtask

    task automatic regop(input string tag, input logic [11:0] op);
        apply(tag, 1'b1, 1'b1, 1'b0, op, 1'b0, 1'b0, 16'h0);
    endtask

    task automatic load(input logic [15:0] d);
        apply("R10", 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 1'b0, d);
    endtask

    initial begin
        #20000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7715));
        #1;
        check("R13", "acc",      acc_q, 16'h0);
        check("R13", "ext",      {15'd0, ext_q}, 16'h0);
        check("R13", "strobes",  {13'd0, pc_skip, halt_clr, sc_clr}, 16'h0);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;

        load(16'h1234);
        regop("R3", 12'h200);
        regop("R3", 12'h100);
        regop("R3", 12'h800);
        regop("R3", 12'h400);
        load(16'h0003);
        regop("R3", 12'h100);
        regop("R4", 12'h080);
        load(16'h8000);
        regop("R3", 12'h400);
        regop("R5", 12'h040);
        load(16'hFFFF);
        regop("R6", 12'h020);
        regop("R7", 12'h004);
        regop("R7", 12'h010);
        load(16'h8000);
        regop("R7", 12'h008);
        regop("R7", 12'h002);
        regop("R8", 12'h001);
        regop("R2", 12'h000);
        regop("R9", 12'hA00);
        regop("R9", 12'h018);
        regop("R9", 12'h1C0);
        apply("R1", 1'b1, 1'b1, 1'b1, 12'h800, 1'b0, 1'b0, 16'h0);
        apply("R1", 1'b0, 1'b1, 1'b0, 12'h200, 1'b0, 1'b0, 16'h0);
        apply("R1", 1'b1, 1'b0, 1'b0, 12'h001, 1'b0, 1'b0, 16'h0);
        load(16'hFFFF);
        apply("R11", 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 1'b1, 16'h0002);
        apply("R11", 1'b0, 1'b0, 1'b0, 12'h0, 1'b0, 1'b1, 16'h7000);
        apply("R12", 1'b1, 1'b1, 1'b0, 12'h800, 1'b1, 1'b1, 16'h5555);
        apply("R12", 1'b0, 1'b0, 1'b0, 12'h0, 1'b1, 1'b1, 16'h4321);

        for (int k = 0; k < 400; k++) begin
            logic t3, d7, ib, ld, ad;
            logic [11:0] op;
            t3 = ($urandom % 4) != 0;
            d7 = ($urandom % 4) != 0;
            ib = ($urandom % 4) == 0;
            op = (($urandom % 10) < 7) ? (12'h1 << ($urandom % 12)) : 12'($urandom);
            ld = ($urandom % 3) == 0;
            ad = ($urandom % 3) == 0;
            apply((t3 && d7 && !ib) ? "R9" : "R12", t3, d7, ib, op, ld, ad,
                  16'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule